// File: doc/BRIEF.md
# Alarm Real-Time Clock

This block keeps wall time for a chip that spends most of its life asleep. It runs on a slow clock enable at crystal rate and counts those pulses down to one tick per second. Each tick advances a seconds, minutes, hours and day count. The same tick decrements a stopwatch and is compared against a programmed alarm time. Three events can raise a request: the second tick, an alarm match and the stopwatch reaching zero. Each event latches a sticky status bit and has its own enable bit.

Software uses a single-cycle register write port to set the time, the alarm, the stopwatch, the enables and the status clears. A combinational read port returns any register. The interrupt line follows the enabled, pending status at once. The wake line is a registered copy of it, suited to an always-on domain.

Top module: `rtc_alarm_core`

## Requirements
- R1: The prescaler counts only cycles in which `xtal_en` is high. Every TICKS_PER_SEC-th counted pulse produces one second tick (default 32768). Cycles with `xtal_en` low never advance time.
- R2: On a tick, seconds count 0..59. On passing 59, seconds return to 0 and minutes advance. Minutes behave the same way, and their wrap advances hours.
- R3: Hours count 0..23. On passing 23 they return to 0 and the day count advances. The day count wraps modulo 2^DAY_W.
- R4: On each tick, a nonzero stopwatch decrements by one. The tick that takes it from 1 to 0 sets status bit 2. A stopwatch at zero stays at zero and raises no event. A load of zero raises no event either.
- R5: On a tick, status bit 1 is set when the new hour, minute and second equal the stored alarm. The day is not compared. The compare uses the alarm value held before any write in that same cycle.
- R6: Status bit 0 is set on each tick. All status bits are sticky. Writing to address 4 clears each bit written as one. If a set and a clear hit the same bit in the same cycle, the set wins.
- R7: `irq` is high in the same cycle as any status bit whose enable bit is set. `wake` shows the same condition one clock later.
- R8: After reset, every register, `irq` and `wake` read zero.
- R9: A time write loads all fields and restarts the prescaler. A tick that would have occurred in that same cycle is dropped. The next tick follows a full TICKS_PER_SEC counted pulses later.
- R10: The register addresses are as follows. Unused bits and addresses 5..7 read zero.
  - 0: time, packed as sec [5:0], min [11:6], hour [16:12], day [31:17].
  - 1: alarm, using the same sec, min and hour positions; day bits read zero.
  - 2: stopwatch in [15:0].
  - 3: enables in [2:0].
  - 4: status in [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_en | input | 1 | Crystal-rate pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| irq | output | 1 | Enabled pending event |
| wake | output | 1 | Registered wake-up request |

## Verification
Randomly spaced crystal pulses are interleaved with random register writes. This separates a prescaler that counts enabled pulses from one that counts clock cycles. It also exposes any loss of the restart rule when time writes land mid-second.

Directed loads of 23:59:59 and xx:58:59 expose carry-chain errors that random times rarely reach. An alarm set one second ahead, a stopwatch loaded with 2 and then 0, and status clears timed onto a tick distinguish correct edge, priority and sticky behaviour from near misses.

// File: rtl/rtc_pkg.sv
// Shared types and register addresses for the alarm real-time clock.
package rtc_pkg;
    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } hms_t;

    localparam logic [2:0] ADR_TIME  = 3'd0;
    localparam logic [2:0] ADR_ALARM = 3'd1;
    localparam logic [2:0] ADR_SWCH  = 3'd2;
    localparam logic [2:0] ADR_IEN   = 3'd3;
    localparam logic [2:0] ADR_STAT  = 3'd4;

    localparam int EV_SEC = 0;
    localparam int EV_ALM = 1;
    localparam int EV_SWZ = 2;
    localparam int NEV    = 3;

    localparam int DAY_LSB = 17;
endpackage

// File: rtl/rtc_prescaler.sv
// Divides the crystal-rate enable down to a one-cycle second tick.
// Assumes xtal_en is a single-cycle pulse. restart zeroes the phase and
// suppresses any tick in the same cycle.
module rtc_prescaler #(
    parameter int TICKS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_en,
    input  logic restart,
    output logic sec_tick
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] phase;

    // tick on the last counted pulse of a second
    assign sec_tick = xtal_en && (phase == LAST) && !restart;

    // phase counter over crystal pulses
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (restart) phase <= '0;
        else if (xtal_en) phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);  // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xtal_en && !restart |=> $stable(phase));  // R1

    generate
        if (TICKS > 1) begin : g_gap
            AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
                sec_tick |=> !sec_tick);  // R1
        end
    endgenerate
endmodule

// File: rtl/rtc_timekeep.sv
// Time-of-day counter: seconds, minutes, hours and a free-running day count.
// Assumes loaded fields are in range. A load has priority over a tick.
module rtc_timekeep
    import rtc_pkg::*;
#(
    parameter int DAY_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  hms_t             load_hms,
    input  logic [DAY_W-1:0] load_day,
    output hms_t             hms_q,
    output logic [DAY_W-1:0] day_q,
    output hms_t             hms_next
);
    logic sec_wrap, min_wrap, hour_wrap;

    // carry chain for the next second
    always_comb begin
        sec_wrap  = (hms_q.sec == 6'd59);
        min_wrap  = sec_wrap && (hms_q.min == 6'd59);
        hour_wrap = min_wrap && (hms_q.hour == 5'd23);
        hms_next.sec  = sec_wrap ? 6'd0 : hms_q.sec + 6'd1;
        hms_next.min  = min_wrap ? 6'd0 : (sec_wrap ? hms_q.min + 6'd1 : hms_q.min);
        hms_next.hour = hour_wrap ? 5'd0 : (min_wrap ? hms_q.hour + 5'd1 : hms_q.hour);
    end

    // time registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hms_q <= '0;
            day_q <= '0;
        end else if (load) begin
            hms_q <= load_hms;
            day_q <= load_day;
        end else if (tick) begin
            hms_q <= hms_next;
            if (hour_wrap) day_q <= day_q + 1'b1;
        end
    end

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && hms_q.sec == 6'd59 |=> hms_q.sec == 6'd0);  // R2
    AST_MIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && hms_q.sec == 6'd59 && hms_q.min != 6'd59
        |=> hms_q.min == $past(hms_q.min) + 6'd1);  // R2
    AST_DAY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && hms_q.hour == 5'd23 && hms_q.min == 6'd59 && hms_q.sec == 6'd59
        |=> hms_q.hour == 5'd0 && day_q == $past(day_q) + 1'b1);  // R3
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !load |=> $stable(hms_q) && $stable(day_q));  // R1
endmodule

// File: rtl/rtc_stopwatch.sv
// Down-counting stopwatch, one step per second tick, halting at zero.
// A load has priority over a tick. zero_evt pulses on the 1 -> 0 step.
module rtc_stopwatch #(
    parameter int SW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            load,
    input  logic [SW_W-1:0] load_val,
    output logic [SW_W-1:0] count,
    output logic            zero_evt
);
    localparam logic [SW_W-1:0] ONE = SW_W'(1);

    // event on the step that reaches zero
    assign zero_evt = tick && !load && (count == ONE);

    // countdown register
    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (load)                   count <= load_val;
        else if (tick && count != '0)    count <= count - ONE;
    end

    AST_SW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && count != '0 |=> count == $past(count) - ONE);  // R4
    AST_SW_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && count == '0 |=> count == '0);  // R4
endmodule

// File: rtl/rtc_events.sv
// Sticky event flags with write-one-to-clear, enables, irq and wake.
// Assumes set and clr are single-cycle. A set beats a clear on the same bit.
module rtc_events #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic         ien_wr,
    input  logic [N-1:0] ien_d,
    output logic [N-1:0] stat,
    output logic [N-1:0] ien,
    output logic         irq,
    output logic         wake
);
    // pending and enabled
    assign irq = |(stat & ien);

    // status, enable and wake registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
            ien  <= '0;
            wake <= 1'b0;
        end else begin
            stat <= (stat & ~clr) | set;
            if (ien_wr) ien <= ien_d;
            wake <= |(stat & ien);
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                stat[i] && !clr[i] |=> stat[i]);  // R6
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                set[i] |=> stat[i]);  // R6
        end
    endgenerate

    AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> wake);  // R7
    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |=> !wake);  // R7
endmodule

// File: rtl/rtc_alarm_core.sv
// Alarm real-time clock top: prescaler, time of day, stopwatch and events,
// with a simple register write port and a combinational read port.
// Assumes DAY_W + 17 <= 32 and SW_W <= 32, and that software loads valid
// time fields.
module rtc_alarm_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int DAY_W         = 15,
    parameter int SW_W          = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xtal_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        irq,
    output logic        wake
);
    logic             time_wr, alarm_wr, sw_wr, ien_wr, stat_wr;
    logic             sec_tick, sw_zero, alarm_hit;
    hms_t             cur_hms, nxt_hms, alarm_q;
    logic [DAY_W-1:0] cur_day;
    logic [SW_W-1:0]  sw_count;
    logic [NEV-1:0]   ev_set, ev_clr, stat, ien;

    // write decode
    always_comb begin
        time_wr  = wr_en && (wr_addr == ADR_TIME);
        alarm_wr = wr_en && (wr_addr == ADR_ALARM);
        sw_wr    = wr_en && (wr_addr == ADR_SWCH);
        ien_wr   = wr_en && (wr_addr == ADR_IEN);
        stat_wr  = wr_en && (wr_addr == ADR_STAT);
    end

    rtc_prescaler #(.TICKS(TICKS_PER_SEC)) u_presc (
        .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en),
        .restart(time_wr), .sec_tick(sec_tick)
    );

    rtc_timekeep #(.DAY_W(DAY_W)) u_time (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(time_wr),
        .load_hms(wr_data[16:0]), .load_day(wr_data[DAY_LSB +: DAY_W]),
        .hms_q(cur_hms), .day_q(cur_day), .hms_next(nxt_hms)
    );

    rtc_stopwatch #(.SW_W(SW_W)) u_sw (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(sw_wr),
        .load_val(wr_data[SW_W-1:0]), .count(sw_count), .zero_evt(sw_zero)
    );

    // alarm register
    always_ff @(posedge clk) begin
        if (!rst_n)        alarm_q <= '0;
        else if (alarm_wr) alarm_q <= wr_data[16:0];
    end

    // alarm compare against the time about to be loaded by the tick
    assign alarm_hit = sec_tick && (nxt_hms == alarm_q);

    // event vectors
    always_comb begin
        ev_set         = '0;
        ev_set[EV_SEC] = sec_tick;
        ev_set[EV_ALM] = alarm_hit;
        ev_set[EV_SWZ] = sw_zero;
        ev_clr         = stat_wr ? wr_data[NEV-1:0] : '0;
    end

    rtc_events #(.N(NEV)) u_ev (
        .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(ev_clr),
        .ien_wr(ien_wr), .ien_d(wr_data[NEV-1:0]),
        .stat(stat), .ien(ien), .irq(irq), .wake(wake)
    );

    // read multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_TIME: begin
                rd_data[16:0]              = cur_hms;
                rd_data[DAY_LSB +: DAY_W]  = cur_day;
            end
            ADR_ALARM: rd_data[16:0]      = alarm_q;
            ADR_SWCH:  rd_data[SW_W-1:0]  = sw_count;
            ADR_IEN:   rd_data[NEV-1:0]   = ien;
            ADR_STAT:  rd_data[NEV-1:0]   = stat;
            default:   rd_data            = '0;
        endcase
    end

    AST_ALARM_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> stat[EV_ALM] && cur_hms == $past(alarm_q));  // R5
    AST_WRITE_DROPS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr |-> !sec_tick);  // R9
    AST_LOAD_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr |=> cur_hms == $past(wr_data[16:0]));  // R9
endmodule

// File: tb/tb_rtc_alarm_core.sv
module tb_rtc_alarm_core;
    localparam int T = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    int          m_pc = 0;
    logic [31:0] m_time = '0;
    logic [16:0] m_alm = '0;
    logic [15:0] m_sw = '0;
    logic [2:0]  m_ien = '0, m_stat = '0;
    logic        m_wake = 1'b0;

    always #2 clk = ~clk;

    rtc_alarm_core #(.TICKS_PER_SEC(T)) dut (
        .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .wake(wake)
    );

    function automatic logic [31:0] pk(int d, int h, int m, int s);
        return {d[14:0], h[4:0], m[5:0], s[5:0]};
    endfunction

    // one second later, per R2/R3
    function automatic logic [31:0] adv(logic [31:0] t);
        logic [5:0] s, m; logic [4:0] h; logic [14:0] d;
        s = t[5:0]; m = t[11:6]; h = t[16:12]; d = t[31:17];
        if (s == 59) begin
            s = 0;
            if (m == 59) begin
                m = 0;
                if (h == 23) begin h = 0; d = d + 1; end else h = h + 1;
            end else m = m + 1;
        end else s = s + 1;
        return {d, h, m, s};
    endfunction

    function automatic logic [31:0] rd_model(logic [2:0] a);
        case (a)
            3'd0: return m_time;
            3'd1: return {15'd0, m_alm};
            3'd2: return {16'd0, m_sw};
            3'd3: return {29'd0, m_ien};
            3'd4: return {29'd0, m_stat};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string tag, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock: drive, update the reference at the edge, then compare
    task automatic cyc(bit xe, bit we, logic [2:0] wa, logic [31:0] wd,
                       logic [2:0] ra, string tag);
        bit tw, tick, swz, ahit;
        logic [31:0] nt;
        logic [2:0] clr;
        bit wk;
        xtal_en = xe; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        @(posedge clk);
        tw   = we && wa == 3'd0;
        tick = xe && !tw && (m_pc == T - 1);
        if (tw) m_pc = 0; else if (xe) m_pc = (m_pc == T - 1) ? 0 : m_pc + 1;
        nt   = adv(m_time);
        ahit = tick && (nt[16:0] == m_alm);
        if (tw) m_time = wd; else if (tick) m_time = nt;
        swz = 0;
        if (we && wa == 3'd2) m_sw = wd[15:0];
        else if (tick && m_sw != 0) begin
            if (m_sw == 1) swz = 1;
            m_sw = m_sw - 1;
        end
        wk = |(m_stat & m_ien);
        clr = (we && wa == 3'd4) ? wd[2:0] : 3'd0;
        m_stat = (m_stat & ~clr) | {swz, ahit, tick};
        if (we && wa == 3'd3) m_ien = wd[2:0];
        if (we && wa == 3'd1) m_alm = wd[16:0];
        m_wake = wk;
        @(negedge clk);
        xtal_en = 0; wr_en = 0;
        check(rd_data, rd_model(ra), tag, "rd_data");
        check({31'd0, irq}, {31'd0, |(m_stat & m_ien)}, "R7", "irq");
        check({31'd0, wake}, {31'd0, m_wake}, "R7", "wake");
    endtask

    task automatic pulses(int n, logic [2:0] ra, string tag);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, ra, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R8: reset state of every register
        for (int a = 0; a < 8; a++) cyc(0, 0, 0, 0, a[2:0], "R8");
        // R10: time field packing read back
        cyc(0, 1, 3'd0, pk(5, 23, 59, 59), 3'd0, "R10");
        // R3: hour and day carry
        pulses(T, 3'd0, "R3");
        check(rd_data, pk(6, 0, 0, 0), "R3", "day rollover");
        // R3: day wraps modulo 2^15
        cyc(0, 1, 3'd0, pk(32767, 23, 59, 59), 3'd0, "R3");
        pulses(T, 3'd0, "R3");
        check(rd_data, pk(0, 0, 0, 0), "R3", "day wrap");
        // R2: minute carry
        cyc(0, 1, 3'd0, pk(0, 7, 58, 59), 3'd0, "R2");
        pulses(T, 3'd0, "R2");
        check(rd_data, pk(0, 7, 59, 0), "R2", "minute carry");
        // R1: idle cycles do not advance
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 3'd0, "R1");
        check(rd_data, pk(0, 7, 59, 0), "R1", "idle hold");
        // R9: write restarts prescaler and drops a coincident tick
        pulses(T - 1, 3'd0, "R9");
        cyc(1, 1, 3'd0, pk(1, 1, 1, 1), 3'd0, "R9");
        pulses(T - 1, 3'd0, "R9");
        check(rd_data, pk(1, 1, 1, 1), "R9", "no early tick");
        pulses(1, 3'd0, "R9");
        check(rd_data, pk(1, 1, 1, 2), "R9", "full period");
        // R5: alarm one second ahead
        cyc(0, 1, 3'd3, 32'd7, 3'd3, "R10");
        cyc(0, 1, 3'd4, 32'd7, 3'd4, "R6");
        cyc(0, 1, 3'd1, pk(9, 1, 1, 3), 3'd1, "R5");
        check(rd_data, pk(0, 1, 1, 3), "R10", "alarm day bits");
        pulses(T, 3'd4, "R5");
        check(rd_data, 32'd3, "R5", "alarm flag");
        // R6: clear one bit only, then set wins over clear
        cyc(0, 1, 3'd4, 32'd2, 3'd4, "R6");
        check(rd_data, 32'd1, "R6", "w1c");
        pulses(T - 1, 3'd4, "R6");
        cyc(1, 1, 3'd4, 32'd1, 3'd4, "R6");
        check(rd_data, 32'd1, "R6", "set wins");
        // R4: stopwatch reaches zero, then parks; zero load silent
        cyc(0, 1, 3'd4, 32'd7, 3'd4, "R6");
        cyc(0, 1, 3'd2, 32'd2, 3'd2, "R4");
        pulses(3 * T, 3'd2, "R4");
        check(rd_data, 32'd0, "R4", "parked");
        cyc(0, 0, 0, 0, 3'd4, "R4");
        check(rd_data[2], 1'b1, "R4", "zero flag");
        cyc(0, 1, 3'd4, 32'd7, 3'd4, "R4");
        cyc(0, 1, 3'd2, 32'd0, 3'd2, "R4");
        pulses(2 * T, 3'd4, "R4");
        check(rd_data[2], 1'b0, "R4", "no event on zero load");
        // random phase
        for (int i = 0; i < 30000; i++) begin
            bit xe, we;
            logic [2:0] wa, ra;
            logic [31:0] wd;
            xe = ($urandom % 2) == 0;
            we = ($urandom % 48) == 0;
            wa = 3'($urandom % 5);
            ra = 3'($urandom % 8);
            case (wa)
                3'd0: wd = pk($urandom % 32768, $urandom % 24, $urandom % 60, $urandom % 60);
                3'd1: wd = {15'd0, adv(adv(m_time))[16:0]};
                3'd2: wd = $urandom % 8;
                default: wd = $urandom % 8;
            endcase
            cyc(xe, we, wa, wd, ra, "R1");
        end
        finish_run();
    end
endmodule